// File: doc/BRIEF.md
# Successive Approximation ADC Controller

This block is the digital half of an 8-bit successive approximation converter. Software sees two byte-wide registers on a small register bus: a control/status register and a read-only result register. Writing the control register with the power bit set launches one conversion frame. The frame is a fixed number of converter clocks: a sampling window, during which the analog front end is told to charge its hold capacitor, followed by an approximation window. In the approximation window the controller tries one result bit at a time, from the most significant bit down. It drives a trial code to an external DAC and reads back one comparator bit.

Each bit trial first lets the DAC and comparator settle for a few clocks and then registers the comparator. When the last trial closes, the finished code is written into the result register and a completion flag is raised in the status register. The flag stays set until software writes the control register again. The channel field of the control register is driven straight out to the analog input multiplexer.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register and the result register read 0x00, and pwr_on, sample_en, chan_sel and dac_code are all 0.
- R2: Register map:
  - Address 0x1E holds the control/status register. Bit 7 is the read-only completion flag, bit 5 is power-on, and bits 2:0 are the channel, which is driven on chan_sel. Bits 6, 4 and 3 read 0.
  - Address 0x1D holds the result register, which is read-only.
  - Any other address reads 0x00.
- R3: A write to 0x1E with bit 5 set starts a new conversion. The write edge is clock 0 of the frame, and the write clears the completion flag at that same edge.
- R4: sample_en is high for exactly frame clocks 1 to 12 and low otherwise.
- R5: Frame clocks 13 to 32 hold 8 bit trials, MSB first. Trials 0 to 3 last 3 clocks each and trials 4 to 7 last 2 clocks each. During trial t, dac_code equals the bits already kept OR'd with bit 7-t. The comparator input cmp_hi is registered on the last clock of each trial, and cmp_hi = 1 keeps the bit.
- R6: On the edge that ends frame clock 32, the code is latched into the result register and the completion flag is set. The flag reads 0 after 31 edges and 1 after 32 edges. The result register changes at no other time.
- R7: With a comparator that reports input >= dac_code, the result equals the input level: full scale gives 0xFF, half scale (128) gives 0x80, and zero gives 0x00.
- R8: A write to 0x1E with bit 5 clear starts no conversion and aborts one in progress. sample_en stays low, the completion flag is cleared and stays clear, and the result register keeps its value.
- R9: A power-on write during a conversion restarts the frame at clock 0. Completion then comes 32 clocks after the second write, with the result of the new frame.
- R10: Reading the result register any number of times does not clear the completion flag. Writes to 0x1D or to unmapped addresses change no register and start no conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational, no side effect) |
| pwr_on | output | 1 | Power-on bit to the analog front end |
| chan_sel | output | 3 | Analog multiplexer channel select |
| sample_en | output | 1 | High during the sampling window |
| dac_code | output | 8 | Trial code for the external DAC |
| cmp_hi | input | 1 | Comparator result: 1 when input >= DAC level |

## Verification
The assertions assume that the comparator input is settled by the last clock of each trial. They also assume that register writes are single-cycle strobes, so the frame counter kept in the checker can be restarted by each power-on write. The stimulus meets this by driving all bus inputs on the falling edge and by modelling the comparator as a purely combinational compare of a held input level against dac_code. The input level changes only between frames, or at the moment of a restart write.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SEQ_CNT_W = 8;
    localparam int CH_W      = 3;
    localparam int BIT_DONE  = 7;
    localparam int BIT_PWR   = 5;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_APPROX = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [SEQ_CNT_W-1:0]   cnt;
        logic [SEQ_CNT_W-1:0]   trial;
        logic [SEQ_CNT_W-1:0]   step;
    } seq_state_t;

    typedef struct packed {
        logic            done;
        logic            pwr;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    // Length in clocks of trial idx when approx clocks are spread over width trials.
    // Leftover clocks go to the most significant trials.
    function automatic int trial_len(input int idx, input int width, input int approx);
        int base;
        int extra;
        base  = approx / width;
        extra = approx % width;
        return (idx < extra) ? base + 1 : base;
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c);
        logic [7:0] r;
        r               = '0;
        r[BIT_DONE]     = c.done;
        r[BIT_PWR]      = c.pwr;
        r[CH_W-1:0]     = c.chan;
        return r;
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SAMPLE_CLKS = 12,
    parameter int APPROX_CLKS = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 abort,
    output logic                 sample_en,
    output logic                 trial_active,
    output logic                 trial_last,
    output logic                 frame_done,
    output logic [SEQ_CNT_W-1:0] trial_idx
);

    localparam logic [SEQ_CNT_W-1:0] SAMPLE_LAST = SEQ_CNT_W'(SAMPLE_CLKS - 1);
    localparam logic [SEQ_CNT_W-1:0] TRIAL_LAST  = SEQ_CNT_W'(RES_W - 1);
    localparam logic [SEQ_CNT_W-1:0] ONE         = SEQ_CNT_W'(1);

    seq_state_t           st;
    seq_state_t           st_nx;
    logic [SEQ_CNT_W-1:0] len_cur;

    always_comb begin
        len_cur = SEQ_CNT_W'(trial_len(int'(st.trial), RES_W, APPROX_CLKS));
    end

    // Trial close and frame close are decoded from the state alone.
    // A coinciding write is resolved by the consumers.
    always_comb begin
        trial_last = (st.phase == PH_APPROX) && (st.step == len_cur - ONE);
        frame_done = trial_last && (st.trial == TRIAL_LAST);
    end

    always_comb begin
        st_nx = st;
        if (start) begin
            st_nx.phase = PH_SAMPLE;
            st_nx.cnt   = '0;
            st_nx.trial = '0;
            st_nx.step  = '0;
        end else if (abort) begin
            st_nx.phase = PH_IDLE;
            st_nx.cnt   = '0;
            st_nx.trial = '0;
            st_nx.step  = '0;
        end else begin
            case (st.phase)
                PH_SAMPLE: begin
                    if (st.cnt == SAMPLE_LAST) begin
                        st_nx.phase = PH_APPROX;
                        st_nx.trial = '0;
                        st_nx.step  = '0;
                    end else begin
                        st_nx.cnt = st.cnt + ONE;
                    end
                end
                PH_APPROX: begin
                    if (trial_last) begin
                        if (st.trial == TRIAL_LAST) begin
                            st_nx.phase = PH_IDLE;
                        end else begin
                            st_nx.trial = st.trial + ONE;
                        end
                        st_nx.step = '0;
                    end else begin
                        st_nx.step = st.step + ONE;
                    end
                end
                default: begin
                    st_nx.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_IDLE;
            st.cnt   <= '0;
            st.trial <= '0;
            st.step  <= '0;
        end else begin
            st <= st_nx;
        end
    end

    assign sample_en    = (st.phase == PH_SAMPLE);
    assign trial_active = (st.phase == PH_APPROX);
    assign trial_idx    = st.trial;

endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 trial_active,
    input  logic                 trial_last,
    input  logic [SEQ_CNT_W-1:0] trial_idx,
    input  logic                 cmp_hi,
    output logic [RES_W-1:0]     dac_code,
    output logic [RES_W-1:0]     result_nx
);

    logic [RES_W-1:0] kept;
    logic [RES_W-1:0] probe;

    // One-hot trial bit: trial 0 probes the MSB.
    always_comb begin
        probe = '0;
        for (int i = 0; i < RES_W; i++) begin
            if (trial_active && (trial_idx == SEQ_CNT_W'(RES_W - 1 - i))) begin
                probe[i] = 1'b1;
            end
        end
    end

    assign dac_code  = kept | probe;
    assign result_nx = kept | (cmp_hi ? probe : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            kept <= '0;
        end else if (start) begin
            kept <= '0;
        end else if (trial_last && cmp_hi) begin
            kept <= kept | probe;
        end
    end

endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h1E,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 'h1D,
    parameter int                RES_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              frame_done,
    input  logic [RES_W-1:0]  result_nx,
    output logic              start,
    output logic              abort,
    output ctrl_t             ctrl_q,
    output logic [RES_W-1:0]  data_q,
    output logic [7:0]        bus_rdata
);

    logic wr_ctrl;
    logic unused_wbits;

    assign wr_ctrl      = bus_wr && (bus_addr == ADDR_CTRL);
    assign start        = wr_ctrl && bus_wdata[BIT_PWR];
    assign abort        = wr_ctrl && !bus_wdata[BIT_PWR];
    assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[4:3]};

    // A control write takes priority over a frame closing in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.done <= 1'b0;
            ctrl_q.pwr  <= 1'b0;
            ctrl_q.chan <= '0;
            data_q      <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.done <= 1'b0;
            ctrl_q.pwr  <= bus_wdata[BIT_PWR];
            ctrl_q.chan <= bus_wdata[CH_W-1:0];
        end else if (frame_done) begin
            ctrl_q.done <= 1'b1;
            data_q      <= result_nx;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = pack_ctrl(ctrl_q);
        end else if (bus_addr == ADDR_DATA) begin
            bus_rdata[RES_W-1:0] = data_q;
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL   = 'h1E,
    parameter logic [ADDR_W-1:0] ADDR_DATA   = 'h1D,
    parameter int                RES_W       = 8,
    parameter int                SAMPLE_CLKS = 12,
    parameter int                APPROX_CLKS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              pwr_on,
    output logic [CH_W-1:0]   chan_sel,
    output logic              sample_en,
    output logic [RES_W-1:0]  dac_code,
    input  logic              cmp_hi
);

    logic                 seq_start;
    logic                 seq_abort;
    logic                 wr_ctrl;
    logic                 trial_active;
    logic                 trial_last;
    logic                 frame_done;
    logic [SEQ_CNT_W-1:0] trial_idx;
    logic [RES_W-1:0]     result_nx;
    logic [RES_W-1:0]     data_q;
    ctrl_t                ctrl_q;
    logic                 done_flag;

    sar_regs #(
        .ADDR_W    (ADDR_W),
        .ADDR_CTRL (ADDR_CTRL),
        .ADDR_DATA (ADDR_DATA),
        .RES_W     (RES_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .frame_done (frame_done),
        .result_nx  (result_nx),
        .start      (seq_start),
        .abort      (seq_abort),
        .ctrl_q     (ctrl_q),
        .data_q     (data_q),
        .bus_rdata  (bus_rdata)
    );

    sar_seq #(
        .RES_W       (RES_W),
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .APPROX_CLKS (APPROX_CLKS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (seq_start),
        .abort        (seq_abort),
        .sample_en    (sample_en),
        .trial_active (trial_active),
        .trial_last   (trial_last),
        .frame_done   (frame_done),
        .trial_idx    (trial_idx)
    );

    sar_approx #(
        .RES_W (RES_W)
    ) u_approx (
        .clk          (clk),
        .rst          (rst),
        .start        (seq_start),
        .trial_active (trial_active),
        .trial_last   (trial_last),
        .trial_idx    (trial_idx),
        .cmp_hi       (cmp_hi),
        .dac_code     (dac_code),
        .result_nx    (result_nx)
    );

    assign wr_ctrl   = seq_start | seq_abort;
    assign done_flag = ctrl_q.done;
    assign pwr_on    = ctrl_q.pwr;
    assign chan_sel  = ctrl_q.chan;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int RES_W       = 8,
    parameter int SAMPLE_CLKS = 12,
    parameter int APPROX_CLKS = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             wr_ctrl,
    input logic             pwr_on,
    input logic             sample_en,
    input logic             done_flag,
    input logic [RES_W-1:0] data_q
);

    logic       seen;
    logic [6:0] since;

    // Clocks elapsed since the last power-on write, saturating.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            since <= '0;
        end else if (start) begin
            seen  <= 1'b1;
            since <= '0;
        end else if (since != 7'd127) begin
            since <= since + 7'd1;
        end
    end

    assert_power_gate_R8: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> pwr_on);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> !done_flag);

    assert_sample_window_R4: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (seen && (since < 7'(SAMPLE_CLKS))));

    assert_done_timing_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (seen && (since == 7'(SAMPLE_CLKS + APPROX_CLKS))));

    assert_data_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        (data_q != $past(data_q)) |-> (done_flag && !$past(done_flag)));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .RES_W       (RES_W),
    .SAMPLE_CLKS (SAMPLE_CLKS),
    .APPROX_CLKS (APPROX_CLKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (seq_start),
    .wr_ctrl   (wr_ctrl),
    .pwr_on    (pwr_on),
    .sample_en (sample_en),
    .done_flag (done_flag),
    .data_q    (data_q)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL     = 8'h1E;
    localparam logic [7:0] A_DATA     = 8'h1D;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       pwr_on;
    logic [2:0] chan_sel;
    logic       sample_en;
    logic [7:0] dac_code;
    logic       cmp_hi;
    logic [7:0] vin;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     rd_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Comparator model: input level compared against the DAC code.
    assign cmp_hi = (vin >= dac_code);

    sar_adc_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwr_on    (pwr_on),
        .chan_sel  (chan_sel),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .cmp_hi    (cmp_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares each result read against the scoreboard.
    initial begin
        forever begin
            @(rd_ev);
            #1;
            if (sb_q.size() == 0) begin
                check("R6 scoreboard underflow", 1, 0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, int'(bus_rdata), int'(it.exp));
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = A_CTRL;
        bus_wdata = 8'h00;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = A_CTRL;
        #1;
    endtask

    function automatic int tlen(input int t);
        return (t < 4) ? 3 : 2;
    endfunction

    // Drives one full frame and traces it clock by clock against R4/R5/R6.
    task automatic convert(input logic [7:0] v, input logic [2:0] ch, input string tag);
        int         bad4;
        int         bad5;
        logic [7:0] expd;
        vin = v;
        sb_q.push_back('{exp: v, tag: tag});
        bus_write(A_CTRL, 8'h20 | {5'd0, ch});
        check("R2 chan_sel", int'(chan_sel), int'(ch));
        check("R3 flag cleared, control readback", int'(bus_rdata), int'(8'h20 | {5'd0, ch}));
        bad4 = 0;
        bad5 = 0;
        for (int k = 0; k < 32; k++) begin
            if (sample_en !== (k < 12)) bad4++;
            if (k >= 12) begin
                int c;
                int t;
                int acc;
                c   = k - 12;
                t   = 0;
                acc = tlen(0);
                while (c >= acc) begin
                    t++;
                    acc += tlen(t);
                end
                expd = (v & ~(8'hFF >> t)) | (8'h80 >> t);
                if (dac_code !== expd) begin
                    if (bad5 == 0)
                        $display("  R5 first mismatch at clock %0d: dac %0h expected %0h", k + 1, dac_code, expd);
                    bad5++;
                end
            end
            if (k == 31) check("R6 flag low after 31 edges", int'(bus_rdata[7]), 0);
            @(negedge clk);
        end
        check("R6 flag high after 32 edges", int'(bus_rdata[7]), 1);
        check("R4 sample window mismatches", bad4, 0);
        check("R5 trial code mismatches", bad5, 0);
        check("R4 sample_en low after frame", int'(sample_en), 0);
        bus_addr = A_DATA;
        #1;
        -> rd_ev;
        #2;
        bus_addr = A_CTRL;
    endtask

    initial begin
        logic [7:0] rv;
        rst       = 1'b1;
        bus_addr  = A_CTRL;
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
        vin       = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        read_at(A_CTRL, rv); check("R1 control after reset", int'(rv), 0);
        read_at(A_DATA, rv); check("R1 result after reset", int'(rv), 0);
        check("R1 sample_en", int'(sample_en), 0);
        check("R1 pwr_on", int'(pwr_on), 0);
        check("R1 chan_sel", int'(chan_sel), 0);
        check("R1 dac_code", int'(dac_code), 0);

        // R7 linearity points, R5 bit patterns
        convert(8'hFF, 3'd5, "R7 full scale result");
        convert(8'h80, 3'd0, "R7 half scale result");
        convert(8'h00, 3'd7, "R7 zero result");
        convert(8'h5A, 3'd2, "R5 pattern 5A result");
        convert(8'hA5, 3'd1, "R5 pattern A5 result");

        // R10 reads have no side effect; stray writes are ignored
        repeat (3) begin
            read_at(A_DATA, rv);
            check("R10 repeated result read", int'(rv), 8'hA5);
        end
        read_at(A_CTRL, rv); check("R10 flag survives reads", int'(rv[7]), 1);
        bus_write(A_DATA, 8'h33);
        check("R10 write to result address starts nothing", int'(sample_en), 0);
        read_at(A_DATA, rv); check("R10 result kept after write to 0x1D", int'(rv), 8'hA5);
        bus_write(8'h00, 8'hFF);
        read_at(A_CTRL, rv); check("R10 control kept after unmapped write", int'(rv), 8'hA1);
        check("R10 unmapped write starts nothing", int'(sample_en), 0);

        // R2 unmapped read, reserved bits, readback after completion
        read_at(8'h00, rv); check("R2 unmapped reads zero", int'(rv), 0);
        vin = 8'h3C;
        bus_write(A_CTRL, 8'hFF);
        check("R2 reserved bits read zero", int'(bus_rdata), 8'h27);
        check("R2 chan_sel all ones", int'(chan_sel), 7);
        repeat (32) @(negedge clk);
        read_at(A_CTRL, rv); check("R2 control readback done", int'(rv), 8'hA7);
        read_at(A_DATA, rv); check("R2 result of frame", int'(rv), 8'h3C);

        // R8 power-off write aborts
        vin = 8'h40;
        bus_write(A_CTRL, 8'h24);
        repeat (5) @(negedge clk);
        bus_write(A_CTRL, 8'h03);
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 40; k++) begin
                if (sample_en || bus_rdata[7]) hi++;
                @(negedge clk);
            end
            check("R8 no sampling or completion after power-off", hi, 0);
        end
        read_at(A_CTRL, rv); check("R8 control after power-off", int'(rv), 8'h03);
        check("R8 pwr_on low", int'(pwr_on), 0);
        read_at(A_DATA, rv); check("R8 result kept", int'(rv), 8'h3C);

        // R9 restart mid-frame
        vin = 8'h11;
        bus_write(A_CTRL, 8'h20);
        repeat (20) @(negedge clk);
        convert(8'h9C, 3'd6, "R9 restart result");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule